// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block runs hardware repeat loops for a small in-order CPU. Software loads a start address, an end address and a 12-bit iteration count. Each time the instruction at the end address completes while more than one iteration remains, the block sends fetch back to the start address and lowers the count by one. No branch instruction is spent on the loop.

Near the tail of the loop, the block tracks a restriction window. Its extent depends on how many 2-byte instructions the loop holds. Inside the window, branch-type, loop-setup and control-register-load instructions are refused as illegal instructions. When an instruction has to be re-executed after an exception, the block also chooses the return address to save. That address depends on the loop length and on where the faulting instruction sits in the window. Decode and exception vectoring live elsewhere: the block receives the current PC, a valid strobe and decoded class flags. It reports a one-cycle redirect or exception pulse in the cycle after the instruction is presented.

Top module: `zol_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count clears to 0 and `redirect_valid` and `exc_valid` read 0 after that edge. The start and end addresses also clear.
- R2: A valid, non-excepting instruction at the end address while the count is greater than 1 produces `redirect_valid`=1 with `redirect_addr` equal to the start address. The pulse lasts one cycle and appears after the next clock edge. In every other case `redirect_valid` is 0.
- R3: Each completion of the end instruction with a nonzero count lowers the count by exactly one. A count of 1 goes to 0 without a redirect. A count of 0 never changes and never redirects.
- R4: A count write (`cfg_count_we`) in the same cycle as an end completion wins: the count takes the written value.
- R5: Loop length L is (end − start)/2 + 1. For L ≤ 3 the window is every instruction of the loop. For L ≥ 4 it is the last three, from end−4 to end. Window positions are numbered 0 to 3 from a detection address. The detection address is the start address for L ≤ 3 and end−6 for L ≥ 4. For L ≥ 4, position 0 lies outside the window.
- R6: Restricted instructions raise an exception with `exc_cause`=2'b01. These are valid instructions that carry `cls_branch`, `cls_rpt_setup` or `cls_ctl_load`, sit inside the window, and execute while the count is nonzero. The same flags outside the window, or while the count is 0, have no effect.
- R7: `reexec_req` on a valid instruction raises an exception with `exc_cause`=2'b10. When it coincides with an illegal instruction, the cause is 2'b01. `exc_cause` is 2'b00 when there is no exception.
- R8: With a count of 2 or more and the faulting PC at window position p, `exc_ret_addr` is set as follows. It is the PC for p = 0 and p = 1. At p = 2 it is detection+2 when L = 3 and start−4 when L ≥ 4. At p = 3 (L ≥ 4) it is start−2.
- R9: With a count of 0 or 1, or with the faulting PC outside the window positions, `exc_ret_addr` equals the faulting PC.
- R10: An exception on the end instruction suppresses both the redirect and the count decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_loop_we | input | 1 | Load start and end addresses |
| cfg_start_addr | input | ADDR_W | Loop start address |
| cfg_end_addr | input | ADDR_W | Loop end address |
| cfg_count_we | input | 1 | Load iteration count |
| cfg_count | input | CNT_W | Iteration count value |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn_pc | input | ADDR_W | Address of the presented instruction |
| cls_branch | input | 1 | Decoded branch, call, return or trap |
| cls_rpt_setup | input | 1 | Decoded loop-setup instruction |
| cls_ctl_load | input | 1 | Decoded load into status, start or end register |
| reexec_req | input | 1 | External re-execution exception on this instruction |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_addr | output | ADDR_W | Redirect target |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 2 | 01 illegal in window, 10 re-execution |
| exc_ret_addr | output | ADDR_W | Return address to save |
| rpt_count | output | CNT_W | Current iteration count |

## Verification
Three things can land on the end instruction in one cycle: a loop-back, an external re-execution request, and an illegal restricted instruction. The bench provokes this with random class flags and re-execution requests at every position of loops one to five instructions long, while the count runs down. It also adds directed cases that place an illegal instruction and a re-execution request on the same PC, or a count write on the end cycle. A reference model in the bench decides which event wins: the exception over the redirect, the illegal cause over the external one, and the written count over the decrement. It then checks the pulse, the cause, the saved address and the next count.

// File: rtl/zol_pkg.sv
// Shared types for the zero-overhead loop controller.
// Assumes fixed 2-byte instructions.
package zol_pkg;
    localparam int INSN_BYTES = 2;

    typedef enum logic [1:0] {
        LEN1  = 2'd0,
        LEN2  = 2'd1,
        LEN3  = 2'd2,
        LEN4P = 2'd3
    } loop_len_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_ILLEGAL = 2'd1,
        CAUSE_REEXEC  = 2'd2
    } exc_cause_e;
endpackage

// File: rtl/zol_window.sv
// Classifies the loop length and locates a PC inside the detection window.
// Assumes end >= start and both addresses 2-byte aligned.
module zol_window
    import zol_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] rpt_start,
    input  logic [ADDR_W-1:0] rpt_end,
    input  logic [ADDR_W-1:0] pc,
    output loop_len_e         len,
    output logic [ADDR_W-1:0] detect_addr,
    output logic              hit,
    output logic [1:0]        pos,
    output logic              restricted
);
    localparam logic [ADDR_W-1:0] ONE_STEP   = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] TWO_STEP   = ADDR_W'(2 * INSN_BYTES);
    localparam logic [ADDR_W-1:0] THREE_STEP = ADDR_W'(3 * INSN_BYTES);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] reach;

    // Loop length class from the byte distance between end and start.
    always_comb begin
        span = rpt_end - rpt_start;
        if (span == '0)            len = LEN1;
        else if (span == ONE_STEP) len = LEN2;
        else if (span == TWO_STEP) len = LEN3;
        else                       len = LEN4P;
    end

    // Detection address, position of the PC and window membership.
    always_comb begin
        detect_addr = (len == LEN4P) ? (rpt_end - THREE_STEP) : rpt_start;
        offset      = pc - detect_addr;
        reach       = rpt_end - detect_addr;
        hit         = (offset <= reach);
        pos         = offset[2:1];
        restricted  = hit && ((len != LEN4P) || (pos != 2'd0));
    end

    // R5: in a short loop a hit never reaches beyond the last instruction.
    always_comb begin
        if (hit && (len != LEN4P)) begin
            assert_pos_in_loop_R5: assert (pos <= 2'(len));
        end
    end
endmodule

// File: rtl/zol_retaddr.sv
// Selects the return address saved for a re-executed instruction.
// Assumes window information from zol_window; purely combinational.
module zol_retaddr
    import zol_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  loop_len_e         len,
    input  logic [1:0]        pos,
    input  logic              hit,
    input  logic              count_ge2,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] detect_addr,
    input  logic [ADDR_W-1:0] rpt_start,
    output logic [ADDR_W-1:0] ret_addr
);
    localparam logic [ADDR_W-1:0] ONE_STEP = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] TWO_STEP = ADDR_W'(2 * INSN_BYTES);

    // Position/length table; falls back to the faulting PC.
    always_comb begin
        ret_addr = pc;
        if (hit && count_ge2) begin
            unique case (pos)
                2'd2: begin
                    if (len == LEN3)       ret_addr = detect_addr + ONE_STEP;
                    else if (len == LEN4P) ret_addr = rpt_start - TWO_STEP;
                end
                2'd3: begin
                    if (len == LEN4P)      ret_addr = rpt_start - ONE_STEP;
                end
                default: ret_addr = pc;
            endcase
        end
    end
endmodule

// File: rtl/zol_count.sv
// Iteration counter: loads on a write, otherwise counts down per loop end.
// Assumes the caller only asserts end_done while the count is nonzero.
module zol_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             end_done,
    output logic [CNT_W-1:0] count
);
    // Count register with write priority over the decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (load_we)    count <= load_val;
        else if (end_done)   count <= count - 1'b1;
    end

    // R3: without a write the count only holds or steps down by one.
    assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_we) && (count != $past(count))) |-> (count == $past(count) - 1'b1));

    // R3: a zero count stays zero without a write.
    assert_zero_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_we && (count == '0)) |=> (count == '0));
endmodule

// File: rtl/zol_ctrl.sv
// Zero-overhead loop controller top: loop registers, redirect generation,
// restriction-window checks and exception reporting, all outputs registered.
// Assumes one instruction per cycle on insn_pc/insn_valid with decoded flags.
module zol_ctrl
    import zol_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_loop_we,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [ADDR_W-1:0] cfg_end_addr,
    input  logic              cfg_count_we,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              insn_valid,
    input  logic [ADDR_W-1:0] insn_pc,
    input  logic              cls_branch,
    input  logic              cls_rpt_setup,
    input  logic              cls_ctl_load,
    input  logic              reexec_req,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              exc_valid,
    output logic [1:0]        exc_cause,
    output logic [ADDR_W-1:0] exc_ret_addr,
    output logic [CNT_W-1:0]  rpt_count
);
    logic [ADDR_W-1:0] rpt_start;
    logic [ADDR_W-1:0] rpt_end;
    loop_len_e         len;
    logic [ADDR_W-1:0] detect_addr;
    logic              hit;
    logic [1:0]        pos;
    logic              restricted;
    logic [ADDR_W-1:0] ret_addr;
    logic              count_nz;
    logic              count_ge2;
    logic              illegal;
    logic              exc_fire;
    logic              end_done;
    exc_cause_e        cause_sel;

    // Loop start/end registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_start <= '0;
            rpt_end   <= '0;
        end else if (cfg_loop_we) begin
            rpt_start <= cfg_start_addr;
            rpt_end   <= cfg_end_addr;
        end
    end

    zol_window #(.ADDR_W(ADDR_W)) u_window (
        .rpt_start   (rpt_start),
        .rpt_end     (rpt_end),
        .pc          (insn_pc),
        .len         (len),
        .detect_addr (detect_addr),
        .hit         (hit),
        .pos         (pos),
        .restricted  (restricted)
    );

    zol_retaddr #(.ADDR_W(ADDR_W)) u_retaddr (
        .len         (len),
        .pos         (pos),
        .hit         (hit),
        .count_ge2   (count_ge2),
        .pc          (insn_pc),
        .detect_addr (detect_addr),
        .rpt_start   (rpt_start),
        .ret_addr    (ret_addr)
    );

    zol_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_we  (cfg_count_we),
        .load_val (cfg_count),
        .end_done (end_done),
        .count    (rpt_count)
    );

    // Exception and loop-end decisions for the presented instruction.
    always_comb begin
        count_nz  = (rpt_count != '0);
        count_ge2 = (rpt_count > CNT_W'(1));
        illegal   = insn_valid && restricted && count_nz &&
                    (cls_branch || cls_rpt_setup || cls_ctl_load);
        exc_fire  = illegal || (insn_valid && reexec_req);
        cause_sel = illegal ? CAUSE_ILLEGAL :
                    (exc_fire ? CAUSE_REEXEC : CAUSE_NONE);
        end_done  = insn_valid && (insn_pc == rpt_end) && !exc_fire && count_nz;
    end

    // Registered redirect and exception pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_addr  <= '0;
            exc_valid      <= 1'b0;
            exc_cause      <= CAUSE_NONE;
            exc_ret_addr   <= '0;
        end else begin
            redirect_valid <= end_done && count_ge2;
            redirect_addr  <= rpt_start;
            exc_valid      <= exc_fire;
            exc_cause      <= cause_sel;
            exc_ret_addr   <= ret_addr;
        end
    end

    // R10: a redirect and an exception never report together.
    assert_no_redirect_on_exc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_valid && exc_valid));

    // R2: a redirect follows a count above one and consumes one iteration.
    assert_redirect_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !$past(cfg_count_we)) |->
            (($past(rpt_count) > CNT_W'(1)) && (rpt_count == $past(rpt_count) - 1'b1)));

    // R7: a reported exception always carries a defined cause.
    assert_cause_defined_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> ((exc_cause == CAUSE_ILLEGAL) || (exc_cause == CAUSE_REEXEC)));

    // R9: with fewer than two iterations left the faulting PC is saved.
    assert_short_count_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && ($past(rpt_count) < CNT_W'(2))) |-> (exc_ret_addr == $past(insn_pc)));

    // R6: with a zero count no illegal cause is reported.
    assert_idle_no_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && ($past(rpt_count) == '0)) |-> (exc_cause == CAUSE_REEXEC));
endmodule

// File: tb/tb_zol_ctrl.sv
`timescale 1ns/1ps
module tb_zol_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_loop_we;
    logic [31:0] cfg_start_addr;
    logic [31:0] cfg_end_addr;
    logic        cfg_count_we;
    logic [11:0] cfg_count;
    logic        insn_valid;
    logic [31:0] insn_pc;
    logic        cls_branch;
    logic        cls_rpt_setup;
    logic        cls_ctl_load;
    logic        reexec_req;
    logic        redirect_valid;
    logic [31:0] redirect_addr;
    logic        exc_valid;
    logic [1:0]  exc_cause;
    logic [31:0] exc_ret_addr;
    logic [11:0] rpt_count;

    int vectors = 0;
    int errors  = 0;

    logic [31:0] S;
    logic [31:0] E;
    int          n;
    logic [11:0] m_cnt;
    logic        last_fire;
    logic        last_redir;

    always #2.5 clk = ~clk;

    zol_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_loop_we(cfg_loop_we), .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
        .cfg_count_we(cfg_count_we), .cfg_count(cfg_count),
        .insn_valid(insn_valid), .insn_pc(insn_pc),
        .cls_branch(cls_branch), .cls_rpt_setup(cls_rpt_setup), .cls_ctl_load(cls_ctl_load),
        .reexec_req(reexec_req),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_ret_addr(exc_ret_addr),
        .rpt_count(rpt_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference return address from loop length, window position and count.
    function automatic logic [31:0] ref_ret(input int len, input int p, input logic h,
                                            input logic [11:0] c, input logic [31:0] pc);
        if (!h || c < 12'd2) return pc;
        if (p == 2 && len == 3) return S + 32'd2;
        if (p == 2 && len >= 4) return S - 32'd4;
        if (p == 3 && len >= 4) return S - 32'd2;
        return pc;
    endfunction

    task automatic idle_inputs();
        cfg_loop_we = 0; cfg_count_we = 0; insn_valid = 0;
        cls_branch = 0; cls_rpt_setup = 0; cls_ctl_load = 0; reexec_req = 0;
    endtask

    task automatic cfg_loop(input logic [31:0] s, input int len, input logic [11:0] c);
        @(negedge clk);
        idle_inputs();
        cfg_loop_we = 1; cfg_start_addr = s; cfg_end_addr = s + 32'(2 * (len - 1));
        cfg_count_we = 1; cfg_count = c;
        @(posedge clk); #1;
        S = s; E = s + 32'(2 * (len - 1)); n = len; m_cnt = c;
        chk("R4 count load", {20'd0, rpt_count}, {20'd0, c});
        @(negedge clk);
        idle_inputs();
    endtask

    // One instruction: drive, predict, check every output after the edge.
    task automatic step(input logic [31:0] p, input logic v, input int cls, input logic rex,
                        input logic cwe, input logic [11:0] cv);
        int idx; int pos;
        logic inl, h, restr, ill, fire, atend, redir;
        logic [31:0] ret;
        logic [1:0]  cause;
        @(negedge clk);
        idle_inputs();
        insn_pc = p; insn_valid = v; reexec_req = rex;
        cls_branch = (cls == 1); cls_rpt_setup = (cls == 2); cls_ctl_load = (cls == 3);
        cfg_count_we = cwe; cfg_count = cv;
        inl   = (p >= S) && (p <= E);
        idx   = (int'(p) - int'(S)) / 2;
        pos   = (n >= 4) ? idx - (n - 4) : idx;
        h     = inl && (pos >= 0);
        restr = h && ((n < 4) || (pos >= 1)) && (m_cnt != 0);
        ill   = v && restr && (cls != 0);
        fire  = ill || (v && rex);
        cause = ill ? 2'b01 : (fire ? 2'b10 : 2'b00);
        ret   = ref_ret(n, pos, h, m_cnt, p);
        atend = v && (p == E) && !fire && (m_cnt != 0);
        redir = atend && (m_cnt > 12'd1);
        @(posedge clk); #1;
        chk("R2 redirect_valid", {31'd0, redirect_valid}, {31'd0, redir});
        if (redir) chk("R2 redirect_addr", redirect_addr, S);
        chk("R6 exc_valid", {31'd0, exc_valid}, {31'd0, fire});
        chk("R7 exc_cause", {30'd0, exc_cause}, {30'd0, cause});
        if (fire) chk("R8 exc_ret_addr", exc_ret_addr, ret);
        m_cnt = cwe ? cv : (atend ? m_cnt - 12'd1 : m_cnt);
        chk("R3 rpt_count", {20'd0, rpt_count}, {20'd0, m_cnt});
        last_fire = fire; last_redir = redir;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        cfg_start_addr = 0; cfg_end_addr = 0; cfg_count = 0; insn_pc = 0;
        S = 0; E = 0; n = 1; m_cnt = 0; last_fire = 0; last_redir = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 count", {20'd0, rpt_count}, 32'd0);
        chk("R1 redirect", {31'd0, redirect_valid}, 32'd0);
        chk("R1 exc", {31'd0, exc_valid}, 32'd0);
        @(negedge clk); rst_n = 1;

        // Random loops of length 1..5 with injected exceptions.
        for (int len = 1; len <= 5; len++) begin
            for (int rep = 0; rep < 3; rep++) begin
                logic [31:0] pc;
                int guard;
                bit done;
                cfg_loop(32'h100 + 32'(len * 32'h40), len, 12'(2 + $urandom % 4));
                pc = S; guard = 0; done = 0;
                while (!done && guard < 300) begin
                    int cls;
                    logic rex;
                    cls = int'($urandom % 7);
                    if (cls > 3) cls = 0;
                    rex = (($urandom % 4) == 0);
                    step(pc, 1'b1, cls, rex, 1'b0, 12'd0);
                    if (last_fire) pc = pc;
                    else if (last_redir) pc = S;
                    else if (pc == E) done = 1;
                    else pc = pc + 32'd2;
                    guard++;
                end
                chk("R3 loop exhausted", {20'd0, rpt_count}, 32'd0);
                // Past the loop end restricted flags do nothing (R6).
                step(E + 32'd2, 1'b1, 1, 1'b0, 1'b0, 12'd0);
                chk("R6 outside window", {31'd0, exc_valid}, 32'd0);
            end
        end

        // Directed: every window position of each length with reexec, count 5.
        for (int len = 1; len <= 5; len++) begin
            for (int k = 0; k < len; k++) begin
                cfg_loop(32'h800, len, 12'd5);
                step(S + 32'(2 * k), 1'b1, 0, 1'b1, 1'b0, 12'd0);
                chk("R8 table", {31'd0, exc_valid}, 32'd1);
            end
        end

        // R5: length 5, position 0 (end-6) is outside the restriction window.
        cfg_loop(32'h900, 5, 12'd4);
        step(E - 32'd6, 1'b1, 1, 1'b0, 1'b0, 12'd0);
        chk("R5 detect slot unrestricted", {31'd0, exc_valid}, 32'd0);
        step(E - 32'd4, 1'b1, 3, 1'b0, 1'b0, 12'd0);
        chk("R5 first restricted slot", {30'd0, exc_cause}, 32'd1);
        step(E - 32'd2, 1'b1, 2, 1'b0, 1'b0, 12'd0);
        chk("R6 setup class", {30'd0, exc_cause}, 32'd1);
        step(E - 32'd2, 1'b1, 0, 1'b1, 1'b0, 12'd0);
        chk("R8 start minus 4", exc_ret_addr, S - 32'd4);

        // R7: illegal and reexec together report illegal.
        step(E, 1'b1, 1, 1'b1, 1'b0, 12'd0);
        chk("R7 illegal wins", {30'd0, exc_cause}, 32'd1);
        // R10: exception on end instruction, no redirect, count unchanged.
        chk("R10 no redirect", {31'd0, redirect_valid}, 32'd0);
        chk("R10 count held", {20'd0, rpt_count}, 32'd4);

        // R4: count write on the end cycle wins over the decrement.
        step(E, 1'b1, 0, 1'b0, 1'b1, 12'd9);
        chk("R4 write wins", {20'd0, rpt_count}, 32'd9);

        // R9: count of 1, reexec at the end position saves the PC.
        cfg_loop(32'h900, 5, 12'd1);
        step(E, 1'b1, 0, 1'b1, 1'b0, 12'd0);
        chk("R9 pc saved", exc_ret_addr, E);
        step(E, 1'b1, 0, 1'b0, 1'b0, 12'd0);
        chk("R3 one to zero no redirect", {31'd0, redirect_valid}, 32'd0);

        // R3/R6: count 0 disables redirect and the window.
        cfg_loop(32'h900, 2, 12'd0);
        step(E, 1'b1, 1, 1'b0, 1'b0, 12'd0);
        chk("R6 zero count no illegal", {31'd0, exc_valid}, 32'd0);
        chk("R3 zero count held", {20'd0, rpt_count}, 32'd0);

        // R1: reset mid-loop clears the count.
        cfg_loop(32'h900, 3, 12'd7);
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1;
        chk("R1 reset clears count", {20'd0, rpt_count}, 32'd0);
        @(negedge clk); rst_n = 1;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule